// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block is the bit-level master of a two-wire serial debug link. It has one clock output and one bidirectional data line. The pad cell is kept outside the block and is modelled here by a data-out, a drive-enable and a data-in signal. The host side presents a 7-bit debug-register address, a read/write flag and 32 bits of write data, then pulses `start`. The block serialises a complete frame and raises a one-cycle `done` pulse. It then returns the 32-bit read data, the 4-bit status word sampled from the target, and an error flag.

A frame has these parts in order:
- a start condition;
- a 10-bit header carrying the address, the direction and a doubled parity bit;
- a 4-bit opcode;
- 32 data bits with a doubled parity bit, driven by the master on a write and by the target on a read;
- a 4-bit status;
- a stop sequence.

A separate line-reset command clocks 100 pulses with the data line high. It then gives one low blip on the data line and lets the line settle. All timing comes from a half-period divider: every half of the output clock lasts `div + 1` cycles of the system clock.

Top module: `twl_master`

## Requirements
- R1: Out of reset and whenever idle, `busy` is 0, `swclk` is 1, `swdo` is 1 and `swdo_oe` is 1.
- R2: A frame opens with one half-period of `swdo` low while `swclk` stays high. Ten header bits follow, most significant first: the address, the write flag (1 = write), then the header parity bit twice. The header parity bit is 1 exactly when the 8 address-plus-flag bits hold an even number of ones.
- R3: After the header, four opcode bits are driven: 0000 on a write and 0001 on a read.
- R4: On a write, the 32 data bits are driven most significant first. They are followed by the data parity bit twice, and that bit is 1 exactly when the data holds an even number of ones.
- R5: On a read, `swdo_oe` is 0 for the 32 data bits, the 2 parity bits and the 4 status bits, 38 bit slots in all. `rdata` takes the first 32 sampled bits, most significant first, and the read parity bits have no effect on `err`. On a write, `swdo_oe` is 0 only for the 4 status bits.
- R6: The 4 status bits are sampled most significant first into `status`. `err` is 0 when the status is 3 or 7 and 1 for any other value.
- R7: Each half-period of `swclk` lasts `div + 1` system clocks. `swdo` never changes at a rising `swclk` edge, and input is sampled at the rising edge. A frame takes 107*(div+1) cycles from the accepting edge to `done`.
- R8: The stop sequence drives `swdo` low with `swdo_oe` 1 while `swclk` is low. Then `swclk` rises with `swdo` still low. Then `swdo` returns high as the frame ends.
- R9: A line reset gives 100 rising `swclk` edges with `swdo` high. It then drives `swdo` low for one half-period with `swclk` high, and holds the line high for SETTLE_HALVES half-periods. It takes (201+SETTLE_HALVES)*(div+1) cycles, and `err` reads 0 afterwards.
- R10: `busy` is 1 from the accepting edge until `done`. `done` is a single-cycle pulse, and `busy` is already 0 while it is high. `start` and `line_rst` have no effect while `busy` is 1. When both arrive together while idle, `start` wins.
- R11: `div` is captured at the accepting edge, so changing it during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a register frame |
| line_rst | input | 1 | Begin a line-reset sequence |
| addr | input | 7 | Debug register address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data |
| div | input | DIV_W | Half-period divider (half-period = div+1 clocks) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 32 | Data from the last read |
| status | output | 4 | Status from the last frame |
| err | output | 1 | Status was neither 3 nor 7 |
| swclk | output | 1 | Link clock |
| swdo | output | 1 | Data-line output value |
| swdo_oe | output | 1 | Data-line drive enable |
| swdi | input | 1 | Data-line input |

## Verification
A table of frames covers both directions and addresses with sparse, all-ones and all-zeros bit patterns, so header and data parity are both seen at 0 and at 1. Divider values from 0 to 3 show whether the frame length scales with the half-period. Status values 3 and 7 are mixed with 0 and 5, which separates a correct status decode from one that tests a single bit. The target model answers reads with inverted parity bits, which shows that read parity has no effect on `err`. Directed cases cover the line reset, a second command arriving mid-transfer, simultaneous start and line reset, and a divider change during a frame.

// File: rtl/twl_pkg.sv
package twl_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 32;
  localparam int STAT_W     = 4;
  localparam int OPC_W      = 4;
  localparam int HDR_BITS   = ADDR_W + 3;                     // addr, wr, parity x2
  localparam int CMD_BITS   = HDR_BITS + OPC_W;               // always driven
  localparam int TX_BITS    = CMD_BITS + DATA_W + 2;          // data + parity x2
  localparam int FRAME_BITS = TX_BITS + STAT_W;
  localparam int RX_W       = DATA_W + 2 + STAT_W;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BITS, S_STOP, S_LBITS, S_LLOW, S_SETTLE
  } state_e;

  // bit that makes (covered bits + one parity copy) hold an odd count of ones
  function automatic logic par_hdr(input logic [ADDR_W:0] v);
    return ~(^v);
  endfunction

  function automatic logic par_data(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic status_ok(input logic [STAT_W-1:0] s);
    return (s == STAT_W'(3)) || (s == STAT_W'(7));
  endfunction

  function automatic logic [TX_BITS-1:0] build_tx(input logic [ADDR_W-1:0] a,
                                                  input logic w,
                                                  input logic [DATA_W-1:0] d);
    logic hp;
    logic dp;
    hp = par_hdr({a, w});
    dp = par_data(d);
    return {a, w, hp, hp, (w ? 4'b0000 : 4'b0001), (w ? d : '0), (w ? {dp, dp} : 2'b00)};
  endfunction

  // data line is driven for the command part, and for the data part of a write
  function automatic logic drive_en(input int unsigned idx, input logic w);
    return (idx < CMD_BITS) || (w && (idx < TX_BITS));
  endfunction
endpackage

// File: rtl/twl_tick.sv
module twl_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (!run) begin
      div_q <= div;          // captured until the transfer starts
      cnt   <= '0;
    end else if (cnt == div_q) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div_q);
endmodule

// File: rtl/twl_seq.sv
module twl_seq
  import twl_pkg::*;
#(
  parameter int RST_PULSES    = 100,
  parameter int SETTLE_HALVES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              line_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [STAT_W-1:0] status,
  output logic              err,
  output logic              sck,
  output logic              sdo,
  output logic              oe,
  output logic              smp
);
  localparam int MAXC  = (FRAME_BITS > RST_PULSES) ?
                         ((FRAME_BITS > SETTLE_HALVES) ? FRAME_BITS : SETTLE_HALVES) :
                         ((RST_PULSES > SETTLE_HALVES) ? RST_PULSES : SETTLE_HALVES);
  localparam int CNT_W = $clog2(MAXC + 1);

  state_e             state;
  logic               ph;      // 0 = clock-low half, 1 = clock-high half
  logic [CNT_W-1:0]   idx;
  logic [TX_BITS-1:0] tx;
  logic [RX_W-1:0]    rx;
  logic               wr_q;

  assign smp = tick && (state == S_BITS) && !ph && !oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph     <= 1'b0;
      idx    <= '0;
      tx     <= '0;
      rx     <= '0;
      wr_q   <= 1'b0;
      sck    <= 1'b1;
      sdo    <= 1'b1;
      oe     <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
      status <= '0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_START;
            tx    <= build_tx(addr, wr, wdata);
            wr_q  <= wr;
            rx    <= '0;
            busy  <= 1'b1;
            sdo   <= 1'b0;                  // start condition, clock held high
          end else if (line_rst) begin
            state <= S_LBITS;
            busy  <= 1'b1;
            idx   <= '0;
            ph    <= 1'b0;
            sck   <= 1'b0;
          end
        end
        S_START: if (tick) begin
          state <= S_BITS;
          idx   <= '0;
          ph    <= 1'b0;
          sck   <= 1'b0;
          sdo   <= tx[TX_BITS-1];
          oe    <= drive_en(0, wr_q);
        end
        S_BITS: if (tick) begin
          if (!ph) begin
            ph  <= 1'b1;
            sck <= 1'b1;
            if (!oe) rx <= {rx[RX_W-2:0], sdi};
          end else if (idx == CNT_W'(FRAME_BITS - 1)) begin
            state <= S_STOP;
            ph    <= 1'b0;
            sck   <= 1'b0;
            sdo   <= 1'b0;
            oe    <= 1'b1;
          end else begin
            ph  <= 1'b0;
            sck <= 1'b0;
            idx <= idx + 1'b1;
            tx  <= {tx[TX_BITS-2:0], 1'b0};
            sdo <= tx[TX_BITS-2];
            oe  <= drive_en(32'(idx) + 1, wr_q);
          end
        end
        S_STOP: if (tick) begin
          if (!ph) begin
            ph  <= 1'b1;
            sck <= 1'b1;
          end else begin
            state  <= S_IDLE;
            ph     <= 1'b0;
            sdo    <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b1;
            status <= rx[STAT_W-1:0];
            err    <= !status_ok(rx[STAT_W-1:0]);
            if (!wr_q) rdata <= rx[RX_W-1 -: DATA_W];
          end
        end
        S_LBITS: if (tick) begin
          if (!ph) begin
            ph  <= 1'b1;
            sck <= 1'b1;
          end else if (idx == CNT_W'(RST_PULSES - 1)) begin
            state <= S_LLOW;
            ph    <= 1'b0;
            sdo   <= 1'b0;
          end else begin
            ph  <= 1'b0;
            sck <= 1'b0;
            idx <= idx + 1'b1;
          end
        end
        S_LLOW: if (tick) begin
          state <= S_SETTLE;
          sdo   <= 1'b1;
          idx   <= '0;
        end
        S_SETTLE: if (tick) begin
          if (idx == CNT_W'(SETTLE_HALVES - 1)) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            err   <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twl_master.sv
module twl_master #(
  parameter int DIV_W         = 8,
  parameter int RST_PULSES    = 100,
  parameter int SETTLE_HALVES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line_rst,
  input  logic [6:0]       addr,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rdata,
  output logic [3:0]       status,
  output logic             err,
  output logic             swclk,
  output logic             swdo,
  output logic             swdo_oe,
  input  logic             swdi
);
  logic tick;   // half-period boundary
  logic smp;    // input sampled at this edge

  twl_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div),
    .tick (tick)
  );

  twl_seq #(.RST_PULSES(RST_PULSES), .SETTLE_HALVES(SETTLE_HALVES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .line_rst(line_rst),
    .addr    (addr),
    .wr      (wr),
    .wdata   (wdata),
    .tick    (tick),
    .sdi     (swdi),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .status  (status),
    .err     (err),
    .sck     (swclk),
    .sdo     (swdo),
    .oe      (swdo_oe),
    .smp     (smp)
  );
endmodule

// File: rtl/twl_master_chk.sv
module twl_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] status,
  input logic       swclk,
  input logic       swdo,
  input logic       swdo_oe,
  input logic       tick,
  input logic       smp
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && swdo && swdo_oe));

  assert_release_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !swdo_oe |-> busy);

  assert_sample_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp |=> (swclk && !swdo_oe));

  assert_err_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !(status == 4'd3 || status == 4'd7));

  assert_no_data_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swclk) |-> $stable(swdo));

  assert_clk_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(swclk) |-> ($past(tick) || $rose(busy)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind twl_master twl_master_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .status (status),
  .swclk  (swclk),
  .swdo   (swdo),
  .swdo_oe(swdo_oe),
  .tick   (tick),
  .smp    (smp)
);

// File: tb/twl_master_test.sv
`timescale 1ns/1ps
module twl_master_test;
  localparam int SETTLE = 20;
  localparam int NVEC   = 6;
  // entry: {wr, addr[6:0], data[31:0], status[3:0], div[3:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b1, 7'h10, 32'h8000_0001, 4'd3, 4'd0},
    {1'b1, 7'h7f, 32'hFFFF_FFFF, 4'd7, 4'd2},
    {1'b0, 7'h11, 32'hA5A5_0F0F, 4'd3, 4'd1},
    {1'b0, 7'h00, 32'h0000_0000, 4'd5, 4'd0},
    {1'b1, 7'h55, 32'h1234_5678, 4'd0, 4'd3},
    {1'b0, 7'h7f, 32'hDEAD_BEEF, 4'd7, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic line_rst = 1'b0;
  logic [6:0] addr = '0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0] div = '0;
  logic busy, done, err, swclk, swdo, swdo_oe;
  logic [31:0] rdata;
  logic [3:0] status;
  logic swdi = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // target model state
  logic [51:0] resp = '0;
  logic [51:0] cap = '0;
  int bitn = 0;
  int rel_cnt = 0;
  int rises = 0;
  int lo_cnt = 0;
  logic stop_ok = 1'b0;

  always #4 clk = ~clk;

  twl_master #(.DIV_W(8), .RST_PULSES(100), .SETTLE_HALVES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .line_rst(line_rst), .addr(addr),
    .wr(wr), .wdata(wdata), .div(div), .busy(busy), .done(done), .rdata(rdata),
    .status(status), .err(err), .swclk(swclk), .swdo(swdo), .swdo_oe(swdo_oe),
    .swdi(swdi)
  );

  always @(negedge swclk) if (bitn < 52) swdi = resp[51-bitn];

  always @(posedge swclk) begin
    rises = rises + 1;
    if (bitn < 52) begin
      cap[51-bitn] = swdo;
      if (!swdo_oe) rel_cnt = rel_cnt + 1;
    end else if (bitn == 52) begin
      stop_ok = (swdo == 1'b0) && swdo_oe;
    end
    bitn = bitn + 1;
  end

  always @(negedge swdo) lo_cnt = lo_cnt + 1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic par(input logic [31:0] v, input int n);
    logic p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ v[i];
    return !p;   // 1 when the count of ones is even
  endfunction

  task automatic arm(input logic [31:0] d, input logic [3:0] st);
    resp = {14'b0, d, ~{par(d, 32), par(d, 32)}, st};
    cap = '0; bitn = 0; rel_cnt = 0; rises = 0; lo_cnt = 0; stop_ok = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic frame(input logic w, input logic [6:0] a, input logic [31:0] d,
                       input logic [3:0] st, input logic [7:0] dv);
    int n;
    logic hp;
    logic dp;
    arm(d, st);
    @(negedge clk);
    wr = w; addr = a; wdata = d; div = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after accept", 64'(busy), 64'(1));
    wait_done(n);
    hp = par({25'b0, a}, 7) ^ w;
    dp = par(d, 32);
    chk("R7", "frame cycles", 64'(n), 64'(107 * (dv + 1)));
    chk("R2", "header", 64'(cap[51:42]), 64'({a, w, hp, hp}));
    chk("R3", "opcode", 64'(cap[41:38]), (w ? 64'(0) : 64'(1)));
    if (w) chk("R4", "write data+parity", 64'(cap[37:4]), 64'({d, dp, dp}));
    chk("R5", "released slots", 64'(rel_cnt), (w ? 64'(4) : 64'(38)));
    if (!w) chk("R5", "rdata", 64'(rdata), 64'(d));
    chk("R6", "status", 64'(status), 64'(st));
    chk("R6", "err", 64'(err), 64'(!(st == 4'd3 || st == 4'd7)));
    chk("R8", "stop low on rise", 64'(stop_ok), 64'(1));
    chk("R8", "lines after stop", 64'({swclk, swdo, swdo_oe}), 64'(3'b111));
    chk("R10", "busy low at done", 64'(busy), 64'(0));
    @(negedge clk);
    chk("R10", "done one cycle", 64'(done), 64'(0));
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "lines in reset", 64'({busy, swclk, swdo, swdo_oe}), 64'(4'b0111));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", 64'({busy, done, err, swclk, swdo, swdo_oe}), 64'(6'b000111));

    for (int i = 0; i < NVEC; i++)
      frame(VEC[i][47], VEC[i][46:40], VEC[i][39:8], VEC[i][7:4], {4'b0, VEC[i][3:0]});

    // R9: line reset after an error frame
    frame(1'b0, 7'h01, 32'h1, 4'd9, 8'd0);
    arm(32'h0, 4'd0);
    bitn = 99;
    @(negedge clk); div = 8'd1; line_rst = 1'b1;
    @(negedge clk); line_rst = 1'b0;
    wait_done(n);
    chk("R9", "reset cycles", 64'(n), 64'((201 + SETTLE) * 2));
    chk("R9", "reset pulses", 64'(rises), 64'(100));
    chk("R9", "data low blips", 64'(lo_cnt), 64'(1));
    chk("R9", "err cleared", 64'(err), 64'(0));
    chk("R1", "idle after reset cmd", 64'({swclk, swdo, swdo_oe}), 64'(3'b111));

    // R10: second commands during a frame are ignored
    arm(32'h0BAD_F00D, 4'd3);
    @(negedge clk); wr = 1'b0; addr = 7'h22; div = 8'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    addr = 7'h6b; wr = 1'b1; start = 1'b1; line_rst = 1'b1; div = 8'd5;
    @(negedge clk); start = 1'b0; line_rst = 1'b0;
    wait_done(n);
    chk("R10", "ignored start: cycles", 64'(n + 31), 64'(107));
    chk("R11", "div change ignored", 64'(n + 31), 64'(107));
    chk("R10", "ignored start: header", 64'(cap[51:44]), 64'({7'h22, 1'b0}));
    chk("R10", "ignored start: rdata", 64'(rdata), 64'(32'h0BAD_F00D));
    repeat (3) @(negedge clk);
    chk("R10", "stays idle after", 64'(busy), 64'(0));

    // R10: start wins over line reset
    arm(32'h0, 4'd7);
    @(negedge clk); wr = 1'b1; addr = 7'h33; wdata = 32'h0; div = 8'd0;
    start = 1'b1; line_rst = 1'b1;
    @(negedge clk); start = 1'b0; line_rst = 1'b0;
    wait_done(n);
    chk("R10", "priority: frame length", 64'(n), 64'(107));
    chk("R2", "priority: header", 64'(cap[51:44]), 64'({7'h33, 1'b1}));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule